// File: doc/BRIEF.md
# Posted-Write Drain Buffer with Per-Word Timeout Discard

This block sits between a processor-side slave port and a downstream write engine. The slave port has already completed a posted burst write upstream, so this block takes the burst data into a small FIFO without checking any address during the data phase. It then offers the buffered words downstream one at a time, using a valid/ready handshake.

When the downstream side takes a word, the next word follows. When the downstream side keeps refusing a word, for example because the word targets an address outside a valid range, a timeout counter runs out for that word. The word is then dropped and the next one is offered, with the counter starting again from zero. The upstream side sees no error for dropped words. Dropped words only raise a one-cycle pulse and advance a saturating drop counter.

A new burst is admitted only after the buffer has fully drained. The `avail_o` output tells the slave port when this is the case.

Top module: `pwb_drain`

## Requirements
- R1: After reset `avail_o` and `up_ready_o` are 1, `dn_valid_o` and `drop_o` are 0, and `drop_cnt_o` is 0.
- R2: Inside an open burst, a beat is taken on every cycle with `up_valid_i` and `up_ready_o` both high, whatever its data content. `up_ready_o` is low only while the buffer holds DEPTH words. A beat with `up_last_i` = 1 closes the burst.
- R3: `dn_valid_o` is high exactly when the buffer is non-empty. Words appear on `dn_data_o` in the order they arrived, and each word stays stable until it is taken or dropped.
- R4: If a presented word sees `dn_ready_i` low on TIMEOUT consecutive presentation cycles, `drop_o` is 1 in the last of those cycles. The word is removed at that edge, and the next word starts with a fresh count of TIMEOUT cycles.
- R5: A word presented with `dn_ready_i` high is consumed at that edge, and `drop_o` stays 0 in that cycle.
- R6: Drops never reach the upstream port. Inside an open burst, `up_ready_o` depends only on buffer occupancy.
- R7: Outside an open burst, `up_ready_o` is 0 while any word is still buffered. A new write is refused until the buffer has drained.
- R8: `avail_o` is 1 exactly when the buffer is empty and no burst is open.
- R9: `drop_cnt_o` counts drops, adding one per `drop_o` pulse, and holds at 2^CNT_W-1 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_valid_i | input | 1 | Upstream beat valid |
| up_ready_o | output | 1 | Upstream beat may be taken |
| up_data_i | input | DATA_W | Upstream beat data |
| up_last_i | input | 1 | Beat is the last of its burst |
| dn_valid_o | output | 1 | A buffered word is presented downstream |
| dn_ready_i | input | 1 | Downstream takes the presented word |
| dn_data_o | output | DATA_W | Presented word |
| drop_o | output | 1 | Presented word is dropped this cycle |
| drop_cnt_o | output | CNT_W | Saturating count of dropped words |
| avail_o | output | 1 | Buffer empty and idle, ready for a new write |

## Verification
The bench sweeps every accept/refuse pattern over bursts of one to six words. Four is the buffer depth, so longer bursts stall on a full buffer while refused words wait out their timeouts.

An off-by-one timeout would show up as a `drop_o` pulse one cycle early or late. A counter that failed to restart would cut short the wait of the word after a drop. Several things would break the in-order comparison: a drop that removed two words, a drop that removed none, or a head word that changed while waiting.

The bench also checks the idle gate cycle by cycle. A design that reopened the slave port before the last dropped word left would be caught. Because the sweep's total drop count runs far past the counter maximum, a counter that wrapped instead of saturating would be caught as well.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // bits needed to hold values 0..n
  function automatic int unsigned val_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // bits needed to index n entries
  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  import pwb_pkg::*;
  localparam int unsigned AW = idx_bits(DEPTH);
  localparam int unsigned CW = val_bits(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] fill_q;

  assign empty_o = (fill_q == '0);
  assign full_o  = (fill_q == CW'(DEPTH));
  assign head_o  = mem[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + AW'(1);
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/pwb_wait_timer.sv
module pwb_wait_timer #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic refused_i,
  input  logic restart_i,
  output logic expire_o
);
  import pwb_pkg::*;
  localparam int unsigned TW = val_bits(TIMEOUT);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;
  logic          waiting;

  assign waiting  = present_i && refused_i;
  assign expire_o = waiting && (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (restart_i || !present_i) cnt_q <= '0;
    else if (waiting)                 cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/pwb_sat_cnt.sv
module pwb_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (inc_i && ~&cnt_o)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              up_last_i,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              drop_o,
  output logic [CNT_W-1:0]  drop_cnt_o,
  output logic              avail_o
);
  logic fifo_empty, fifo_full;
  logic in_burst_q;
  logic push, pop, taken;

  // new burst only on an empty buffer; open burst stalls only when full
  assign up_ready_o = !fifo_full && (in_burst_q || fifo_empty);
  assign push       = up_valid_i && up_ready_o;
  assign dn_valid_o = !fifo_empty;
  assign taken      = dn_valid_o && dn_ready_i;
  assign pop        = taken || drop_o;
  assign avail_o    = fifo_empty && !in_burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_burst_q <= 1'b0;
    else if (push) in_burst_q <= !up_last_i;
  end

  pwb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (up_data_i),
    .pop_i   (pop),
    .head_o  (dn_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  pwb_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .present_i (dn_valid_o),
    .refused_i (!dn_ready_i),
    .restart_i (pop),
    .expire_o  (drop_o)
  );

  pwb_sat_cnt #(.W(CNT_W)) u_drops (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop_o),
    .cnt_o  (drop_cnt_o)
  );
endmodule

// File: rtl/pwb_drain_chk.sv
module pwb_drain_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned CNT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              up_ready_o,
  input logic              dn_valid_o,
  input logic              dn_ready_i,
  input logic [DATA_W-1:0] dn_data_o,
  input logic              drop_o,
  input logic [CNT_W-1:0]  drop_cnt_o,
  input logic              avail_o,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              in_burst_q
);
  import pwb_pkg::*;
  localparam int unsigned TW = val_bits(TIMEOUT);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // independent count of refused cycles for the current head word
  logic [TW-1:0] ck_wait_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_wait_q <= '0;
    else if (!dn_valid_o || dn_ready_i || drop_o) ck_wait_q <= '0;
    else ck_wait_q <= ck_wait_q + TW'(1);
  end

  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !up_ready_o);
  p_head_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i && !drop_o) |=> (dn_valid_o && $stable(dn_data_o)));
  p_drop_refused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (dn_valid_o && !dn_ready_i));
  p_drop_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (ck_wait_q == TW'(TIMEOUT - 1)));
  p_wait_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i) |-> (ck_wait_q < TW'(TIMEOUT)));
  p_no_drop_on_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && dn_ready_i) |-> !drop_o);
  p_idle_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_burst_q && !fifo_empty) |-> !up_ready_o);
  p_avail_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o |-> (!dn_valid_o && up_ready_o));
  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && drop_cnt_o != CMAX) |=> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));
  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == CMAX) |=> (drop_cnt_o == CMAX));
endmodule

bind pwb_drain pwb_drain_chk #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_ready_o (up_ready_o),
  .dn_valid_o (dn_valid_o),
  .dn_ready_i (dn_ready_i),
  .dn_data_o  (dn_data_o),
  .drop_o     (drop_o),
  .drop_cnt_o (drop_cnt_o),
  .avail_o    (avail_o),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .in_burst_q (in_burst_q)
);

// File: tb/pwb_drain_test.sv
`timescale 1ns/1ps
module pwb_drain_test;
  localparam int DATA_W  = 16;
  localparam int DEPTH   = 4;
  localparam int TIMEOUT = 5;
  localparam int CNT_W   = 3;
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int MAX_LEN = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic up_valid_i = 1'b0;
  logic up_ready_o;
  logic [DATA_W-1:0] up_data_i = '0;
  logic up_last_i = 1'b0;
  logic dn_valid_o;
  logic dn_ready_i;
  logic [DATA_W-1:0] dn_data_o;
  logic drop_o;
  logic [CNT_W-1:0] drop_cnt_o;
  logic avail_o;

  always #2.5 clk_i = ~clk_i;

  // downstream refuses any word whose bit 15 is set
  assign dn_ready_i = dn_valid_o && !dn_data_o[15];

  pwb_drain #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) uut (
    .clk_i, .rst_ni, .up_valid_i, .up_ready_o, .up_data_i, .up_last_i,
    .dn_valid_o, .dn_ready_i, .dn_data_o, .drop_o, .drop_cnt_o, .avail_o
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // bench model
  logic [DATA_W-1:0] pend_q[$];
  bit in_b = 1'b0;
  int wait_n = 0;
  int n_acc = 0;
  int n_drop = 0;

  always @(negedge clk_i) begin
    if (mon_on) begin
      int occ;
      bit exp_ready, exp_drop;
      occ = pend_q.size();
      exp_ready = in_b ? (occ < DEPTH) : (occ == 0);
      chk(up_ready_o == exp_ready, in_b ? "R6 ready in burst" : "R7 ready idle",
          int'(up_ready_o), int'(exp_ready));
      chk(avail_o == (occ == 0 && !in_b), "R8 avail", int'(avail_o), int'(occ == 0 && !in_b));
      chk(dn_valid_o == (occ != 0), "R3 valid", int'(dn_valid_o), int'(occ != 0));
      chk(int'(drop_cnt_o) == ((n_drop > CMAX) ? CMAX : n_drop), "R9 drop count",
          int'(drop_cnt_o), (n_drop > CMAX) ? CMAX : n_drop);
      if (dn_valid_o && occ != 0) begin
        chk(dn_data_o == pend_q[0], "R3 order", int'(dn_data_o), int'(pend_q[0]));
        if (dn_ready_i) begin
          chk(!drop_o, "R5 take no drop", int'(drop_o), 0);
          void'(pend_q.pop_front());
          n_acc++;
          wait_n = 0;
        end else begin
          wait_n++;
          exp_drop = (wait_n == TIMEOUT);
          chk(drop_o == exp_drop, "R4 timeout", int'(drop_o), int'(exp_drop));
          if (exp_drop) begin
            void'(pend_q.pop_front());
            n_drop++;
            wait_n = 0;
          end
        end
      end else begin
        chk(!drop_o, "R4 no drop when empty", int'(drop_o), 0);
      end
      if (up_valid_i && up_ready_o) begin
        pend_q.push_back(up_data_i);
        in_b = !up_last_i;
      end
    end
  end

  task automatic send_burst(input int len, input int mask, input int id);
    @(posedge clk_i);
    #1;
    for (int i = 0; i < len; i++) begin
      up_valid_i = 1'b1;
      up_data_i  = {mask[i], 7'(id), 8'(i)};
      up_last_i  = (i == len - 1);
      @(negedge clk_i);
      while (!up_ready_o) @(negedge clk_i);
      @(posedge clk_i);
      #1;
    end
    up_valid_i = 1'b0;
    up_last_i  = 1'b0;
  endtask

  task automatic wait_avail();
    @(negedge clk_i);
    while (!avail_o) @(negedge clk_i);
  endtask

  initial begin
    int id;
    int exp_total;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(avail_o == 1'b1, "R1 avail", int'(avail_o), 1);
    chk(up_ready_o == 1'b1, "R1 up_ready", int'(up_ready_o), 1);
    chk(dn_valid_o == 1'b0, "R1 dn_valid", int'(dn_valid_o), 0);
    chk(drop_o == 1'b0, "R1 drop", int'(drop_o), 0);
    chk(drop_cnt_o == '0, "R1 drop_cnt", int'(drop_cnt_o), 0);
    mon_on = 1'b1;

    // every accept/refuse pattern for bursts of 1..MAX_LEN words
    id = 0;
    for (int len = 1; len <= MAX_LEN; len++) begin
      for (int mask = 0; mask < (1 << len); mask++) begin
        wait_avail();
        send_burst(len, mask, id);
        id++;
      end
    end
    wait_avail();
    repeat (2) @(negedge clk_i);

    // each length contributes len*2^(len-1) refused and accepted words
    exp_total = 0;
    for (int len = 1; len <= MAX_LEN; len++) exp_total += len * (1 << (len - 1));
    chk(n_acc == exp_total, "R5 total taken", n_acc, exp_total);
    chk(n_drop == exp_total, "R4 total dropped", n_drop, exp_total);
    chk(int'(drop_cnt_o) == CMAX, "R9 saturated", int'(drop_cnt_o), CMAX);
    chk(pend_q.size() == 0 && avail_o, "R2 all beats drained", pend_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule